// File: doc/BRIEF.md
# UART interrupt status and mask unit

This block keeps the interrupt state of a serial port. Live status levels from the receive and transmit FIFOs (trigger reached, empty, full) and one-cycle event pulses from the receiver and modem logic (overrun, framing error, parity error, receive timeout, modem line change) are gathered into a sticky cause register. An enable mask selects which causes raise the single level interrupt output. The FIFOs, shifters and baud logic sit outside and only deliver their conditions as inputs.

Software reaches the unit through a small register port with an address, write data, a write strobe and combinational read data. The mask cannot be written directly. Two write-only registers change it: one sets mask bits and the other clears them. The cause register is cleared by writing ones. Because the five FIFO level bits are copied into the cause register on every cycle, a cause that is still active comes straight back after it is cleared.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset the mask, the cause register and `irq` are all zero.
- R2: Cause bits 0..4 are RX-trigger, RX-empty, RX-full, TX-empty and TX-full (`lvl_status[0..4]`). Each is set on any clock edge at which its status input is high, and it stays set after the input falls.
- R3: Cause bits 5..9 are overrun, framing, parity, timeout and modem change (`evt_pulse[0..4]`). A one-cycle pulse sets the bit, and the bit stays set.
- R4: A write to address 0 (mask-set) ORs `reg_wdata[9:0]` into the mask.
- R5: A write to address 1 (mask-clear) clears every mask bit whose `reg_wdata` bit is one. Other mask bits keep their value.
- R6: Address 2 returns the mask in `reg_rdata[9:0]`. A write to address 2 leaves the mask unchanged.
- R7: Address 3 returns the cause register in bits 9..0. A write to it clears each cause bit written as one, and every other bit keeps its value.
- R8: If a set condition (level or event) and a clearing write hit the same cause bit in one cycle, the bit ends up set.
- R9: `irq` is registered. At each edge it takes the OR of (mask AND cause) as those registers stood before that edge, so it follows an update by one clock.
- R10: Reads of addresses 0, 1 and 4..15 return zero, and so do bits 31..10 at every address. Writes to addresses 4..15 change neither the mask nor the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| lvl_status | input | 5 | Live FIFO status levels |
| evt_pulse | input | 5 | One-cycle error and event pulses |
| irq | output | 1 | Level interrupt request |

## Verification
The mask path is swept over all 1024 enable values, each combined with a second, arithmetically derived set pattern and a clear pattern. This separates OR-in, clear-only-ones and keep-the-rest behaviour. Each cause bit is raised alone from its own input, which exposes swapped bit positions and shows that bits stay set. Clearing writes that collide with a held level or an event pulse show whether set wins. Paired mask and cause patterns, including disjoint ones, are checked for `irq` both one edge and two edges after the cause update, which separates the right one-cycle latency from a combinational or late output. Writes to the read-only and unmapped addresses are followed by read-back of both registers.

// File: rtl/uirq_pkg.sv
// Package for the UART interrupt unit: register selector type and the
// bit positions of the cause fields. Assumes a single register port.
package uirq_pkg;

    // Decoded register selected by the current address
    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_MSET  = 3'd1,
        SEL_MCLR  = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_CAUSE = 3'd4
    } reg_sel_e;

    // Default word addresses of the four registers
    localparam int ADDR_MSET_DEF  = 0;
    localparam int ADDR_MCLR_DEF  = 1;
    localparam int ADDR_MASK_DEF  = 2;
    localparam int ADDR_CAUSE_DEF = 3;

    // Position of the first event bit in the cause register
    localparam int EVT_BASE_DEF = 5;

endpackage

// File: rtl/uirq_regdec.sv
// Address decoder: maps the register word address to a selector.
// Assumes the four register addresses are distinct; others map to SEL_NONE.
module uirq_regdec
    import uirq_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int A_MSET  = ADDR_MSET_DEF,
    parameter int A_MCLR  = ADDR_MCLR_DEF,
    parameter int A_MASK  = ADDR_MASK_DEF,
    parameter int A_CAUSE = ADDR_CAUSE_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Compare the address against each register location
    always_comb begin
        if (addr == ADDR_W'(A_MSET))       sel = SEL_MSET;
        else if (addr == ADDR_W'(A_MCLR))  sel = SEL_MCLR;
        else if (addr == ADDR_W'(A_MASK))  sel = SEL_MASK;
        else if (addr == ADDR_W'(A_CAUSE)) sel = SEL_CAUSE;
        else                               sel = SEL_NONE;
    end

endmodule

// File: rtl/uirq_mask.sv
// Interrupt enable mask. It is changed only by set strobes (OR in) and
// clear strobes (AND NOT). Assumes at most one strobe per cycle.
module uirq_mask #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] bits,
    output logic [WIDTH-1:0] mask_q
);

    // Hold the mask; reset clears it
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (set_en) mask_q <= mask_q | bits;
        else if (clr_en) mask_q <= mask_q & ~bits;
    end

endmodule

// File: rtl/uirq_cause.sv
// Sticky cause register. The low N_LVL bits copy live levels and the upper
// N_EVT bits capture event pulses. A set beats a write-one-to-clear.
module uirq_cause #(
    parameter int N_LVL = 5,
    parameter int N_EVT = 5,
    localparam int CW   = N_LVL + N_EVT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [CW-1:0]    clr_bits,
    input  logic [N_LVL-1:0] lvl,
    input  logic [N_EVT-1:0] evt,
    output logic [CW-1:0]    cause_q
);

    logic [CW-1:0] set_vec;

    // Gather all set sources into one vector, levels in the low bits
    always_comb set_vec = {evt, lvl};

    for (genvar g = 0; g < CW; g++) begin : g_bit
        // Per-bit sticky flag; set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)                       cause_q[g] <= 1'b0;
            else if (set_vec[g])              cause_q[g] <= 1'b1;
            else if (clr_en && clr_bits[g])   cause_q[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_irq_unit.sv
// UART interrupt status and mask unit (top). It combines the decoder, the
// mask, the cause register, a registered interrupt output and read mux.
// Assumes DATA_W >= N_LVL + N_EVT and one register access per cycle.
module uart_irq_unit
    import uirq_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int N_LVL   = 5,
    parameter int N_EVT   = 5,
    parameter int A_MSET  = ADDR_MSET_DEF,
    parameter int A_MCLR  = ADDR_MCLR_DEF,
    parameter int A_MASK  = ADDR_MASK_DEF,
    parameter int A_CAUSE = ADDR_CAUSE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_LVL-1:0]  lvl_status,
    input  logic [N_EVT-1:0]  evt_pulse,
    output logic              irq
);

    localparam int CAUSE_W = N_LVL + N_EVT;

    reg_sel_e           sel;
    logic [CAUSE_W-1:0] wbits;
    logic [CAUSE_W-1:0] mask_q;
    logic [CAUSE_W-1:0] cause_q;

    // Only the low cause-width bits of write data are meaningful
    always_comb wbits = reg_wdata[CAUSE_W-1:0];

    if (DATA_W > CAUSE_W) begin : g_hi
        logic unused_wdata_hi;
        always_comb unused_wdata_hi = ^reg_wdata[DATA_W-1:CAUSE_W];
    end

    uirq_regdec #(
        .ADDR_W (ADDR_W),
        .A_MSET (A_MSET),
        .A_MCLR (A_MCLR),
        .A_MASK (A_MASK),
        .A_CAUSE(A_CAUSE)
    ) u_dec (
        .addr(reg_addr),
        .sel (sel)
    );

    uirq_mask #(
        .WIDTH(CAUSE_W)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .set_en(reg_wr && (sel == SEL_MSET)),
        .clr_en(reg_wr && (sel == SEL_MCLR)),
        .bits  (wbits),
        .mask_q(mask_q)
    );

    uirq_cause #(
        .N_LVL(N_LVL),
        .N_EVT(N_EVT)
    ) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (reg_wr && (sel == SEL_CAUSE)),
        .clr_bits(wbits),
        .lvl     (lvl_status),
        .evt     (evt_pulse),
        .cause_q (cause_q)
    );

    // Register the interrupt request from the enabled causes
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(mask_q & cause_q);
    end

    // Select read data; write-only and unmapped addresses read zero
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_MASK:  reg_rdata[CAUSE_W-1:0] = mask_q;
            SEL_CAUSE: reg_rdata[CAUSE_W-1:0] = cause_q;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uirq_checker.sv
// Property checker for uart_irq_unit, attached with bind. Assumes the
// default register addresses are passed down as parameters.
module uirq_checker #(
    parameter int ADDR_W  = 4,
    parameter int N_LVL   = 5,
    parameter int N_EVT   = 5,
    parameter int A_MSET  = 0,
    parameter int A_MCLR  = 1,
    parameter int A_MASK  = 2,
    parameter int A_CAUSE = 3,
    localparam int CW     = N_LVL + N_EVT
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [CW-1:0]     wbits,
    input logic [N_LVL-1:0]  lvl_status,
    input logic [N_EVT-1:0]  evt_pulse,
    input logic              irq,
    input logic [CW-1:0]     mask_q,
    input logic [CW-1:0]     cause_q
);

    logic [CW-1:0] set_now;
    logic          wr_mset, wr_mclr, wr_mask, wr_cause;

    // Decode the register port independently of the design
    always_comb begin
        set_now  = {evt_pulse, lvl_status};
        wr_mset  = reg_wr && (reg_addr == ADDR_W'(A_MSET));
        wr_mclr  = reg_wr && (reg_addr == ADDR_W'(A_MCLR));
        wr_mask  = reg_wr && (reg_addr == ADDR_W'(A_MASK));
        wr_cause = reg_wr && (reg_addr == ADDR_W'(A_CAUSE));
    end

    assert_level_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|lvl_status) |=> ((cause_q[N_LVL-1:0] & $past(lvl_status)) == $past(lvl_status)));

    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((cause_q[CW-1:N_LVL] & $past(evt_pulse)) == $past(evt_pulse)));

    assert_mask_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((mask_q & $past(wbits)) == $past(wbits)));

    assert_mask_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask_q & $past(wbits)) == '0));

    assert_mask_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_q == $past(mask_q)));

    assert_cause_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cause |=> ((cause_q & $past(wbits & ~set_now)) == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cause |=> ((cause_q & $past(set_now)) == $past(set_now)));

    assert_irq_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq == (|($past(mask_q) & $past(cause_q)))));

endmodule

bind uart_irq_unit uirq_checker #(
    .ADDR_W (ADDR_W),
    .N_LVL  (N_LVL),
    .N_EVT  (N_EVT),
    .A_MSET (A_MSET),
    .A_MCLR (A_MCLR),
    .A_MASK (A_MASK),
    .A_CAUSE(A_CAUSE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .wbits     (wbits),
    .lvl_status(lvl_status),
    .evt_pulse (evt_pulse),
    .irq       (irq),
    .mask_q    (mask_q),
    .cause_q   (cause_q)
);

// File: tb/tb_uart_irq_unit.sv
// Self-checking bench for uart_irq_unit: sweeps mask patterns, each cause
// bit, collisions and mask/cause pairs against an arithmetic model.
module tb_uart_irq_unit;

    localparam int AW = 4;
    localparam int DW = 32;
    localparam int CW = 10;
    localparam logic [AW-1:0] A_SET = 4'd0, A_CLR = 4'd1, A_MSK = 4'd2, A_CAU = 4'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          reg_wr = 1'b0;
    logic [DW-1:0] reg_rdata;
    logic [4:0]    lvl_status = '0;
    logic [4:0]    evt_pulse = '0;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;
    logic mon_on = 1'b0;

    // Bench model of the requirement behaviour
    logic [CW-1:0] m_mask, m_cause;
    logic          m_irq;

    uart_irq_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rdata (reg_rdata),
        .lvl_status(lvl_status),
        .evt_pulse (evt_pulse),
        .irq       (irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask <= '0; m_cause <= '0; m_irq <= 1'b0;
        end else begin
            m_irq <= |(m_mask & m_cause);
            if (reg_wr && reg_addr == A_SET) m_mask <= m_mask | reg_wdata[CW-1:0];
            if (reg_wr && reg_addr == A_CLR) m_mask <= m_mask & ~reg_wdata[CW-1:0];
            m_cause <= (m_cause & ~((reg_wr && reg_addr == A_CAU) ? reg_wdata[CW-1:0] : '0))
                       | {evt_pulse, lvl_status};
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R9: irq compared with the model at every cycle after reset
    always @(negedge clk) if (mon_on) chk("R9 irq monitor", {31'b0, irq}, {31'b0, m_irq});

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        reg_addr = a; reg_wr = 1'b0;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state
        rd_chk("R1 mask after reset", A_MSK, 32'h0);
        rd_chk("R1 cause after reset", A_CAU, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        mon_on = 1'b1;

        // R2: each level bit alone, sticky after the input falls
        for (int i = 0; i < 5; i++) begin
            wr_reg(A_CAU, 32'h3FF);
            lvl_status = 5'(1 << i);
            tick();
            lvl_status = '0;
            rd_chk("R2 level bit set", A_CAU, 32'(1 << i));
            tick(); tick();
            rd_chk("R2 level bit sticky", A_CAU, 32'(1 << i));
        end

        // R3: each event bit alone, sticky
        for (int j = 0; j < 5; j++) begin
            wr_reg(A_CAU, 32'h3FF);
            evt_pulse = 5'(1 << j);
            tick();
            evt_pulse = '0;
            tick(); tick();
            rd_chk("R3 event bit sticky", A_CAU, 32'(1 << (5 + j)));
        end

        // R7: partial clear keeps other bits
        wr_reg(A_CAU, 32'h3FF);
        evt_pulse = 5'h1F; lvl_status = 5'h1F;
        tick();
        evt_pulse = '0; lvl_status = '0;
        wr_reg(A_CAU, 32'h0F0);
        rd_chk("R7 partial w1c", A_CAU, 32'h30F);

        // R8: held level collides with clear
        lvl_status = 5'h01;
        wr_reg(A_CAU, 32'h3FF);
        rd_chk("R8 level beats clear", A_CAU, 32'h001);
        lvl_status = '0;
        wr_reg(A_CAU, 32'h3FF);
        rd_chk("R7 cleared after level drops", A_CAU, 32'h000);
        // R8: event pulse collides with clear
        evt_pulse = 5'h01;
        wr_reg(A_CAU, 32'h3FF);
        evt_pulse = '0;
        rd_chk("R8 event beats clear", A_CAU, 32'h020);
        wr_reg(A_CAU, 32'h3FF);

        // R4/R5: mask sweep over all values
        for (int v = 0; v < 1024; v++) begin
            logic [CW-1:0] w;
            w = CW'((v * 37 + 5) & 32'h3FF);
            wr_reg(A_CLR, 32'h3FF);
            wr_reg(A_SET, 32'(v));
            rd_chk("R4 set from zero", A_MSK, 32'(v));
            wr_reg(A_SET, {22'b0, w});
            rd_chk("R4 OR into mask", A_MSK, 32'(v) | {22'b0, w});
            wr_reg(A_CLR, 32'(v));
            rd_chk("R5 clear ones only", A_MSK, {22'b0, w & ~CW'(v)});
        end

        // R6: mask address is read-only
        wr_reg(A_CLR, 32'h3FF);
        wr_reg(A_SET, 32'h155);
        wr_reg(A_MSK, 32'h2AA);
        rd_chk("R6 mask write ignored", A_MSK, 32'h155);

        // R10: unmapped addresses and write-only registers read zero
        evt_pulse = 5'h03;
        tick();
        evt_pulse = '0;
        for (int a = 4; a < 16; a++) begin
            wr_reg(AW'(a), 32'hFFFF_FFFF);
            rd_chk("R10 unmapped reads zero", AW'(a), 32'h0);
        end
        rd_chk("R10 mask untouched", A_MSK, 32'h155);
        rd_chk("R10 cause untouched", A_CAU, 32'h060);
        rd_chk("R10 set reg reads zero", A_SET, 32'h0);
        rd_chk("R10 clear reg reads zero", A_CLR, 32'h0);
        wr_reg(A_CAU, 32'hFFFF_FFFF);

        // R9: mask/cause pairs, irq one edge after the cause update
        for (int k = 0; k < 80; k++) begin
            logic [CW-1:0] p, q;
            p = CW'((k * 97 + 1) & 32'h3FF);
            q = (k % 5 == 0) ? ~p : CW'((k * 53 + 11) & 32'h3FF);
            wr_reg(A_CLR, 32'h3FF);
            wr_reg(A_SET, {22'b0, p});
            wr_reg(A_CAU, 32'h3FF);
            tick();
            lvl_status = q[4:0]; evt_pulse = q[9:5];
            tick();
            lvl_status = '0; evt_pulse = '0;
            chk("R9 irq not yet updated", {31'b0, irq}, 32'h0);
            tick();
            chk("R9 irq after one clock", {31'b0, irq}, {31'b0, |(p & q)});
            wr_reg(A_CAU, 32'h3FF);
        end

        // R1: reset in mid-operation clears everything
        wr_reg(A_SET, 32'h3FF);
        lvl_status = 5'h1F; tick(); lvl_status = '0;
        mon_on = 1'b0;
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        rd_chk("R1 mask after second reset", A_MSK, 32'h0);
        rd_chk("R1 cause after second reset", A_CAU, 32'h0);
        chk("R1 irq after second reset", {31'b0, irq}, 32'h0);

        tick();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule